// File: doc/BRIEF.md
# Four-Drive Programmed-I/O Cycle Timer

This block produces the read and write strobe cycles of programmed I/O for four drives on two channels. Drives 0 and 1 sit on the primary channel, and each of them has its own timing registers. Drives 2 and 3 sit on the secondary channel and share one set of timing registers. Every cycle has three phases: an address-setup phase, an active phase in which the selected strobe is driven, and a recovery phase. The number of clocks in each phase is decoded from the timing register bytes. The decode applies several hardware rules:

- The setup code is not monotonic.
- A nibble of zero stands for sixteen clocks.
- Some minimum-width stretches apply.
- Newer silicon, with a revision above 1, gets one extra recovery clock.

A byte-wide write port loads the timing, command-timing and prefetch-control bytes. A start pulse launches a cycle. It carries a drive index, a read/write flag and a flag that marks an access to the drive's command register block. Command-block cycles take their active and recovery counts from a dedicated command-timing byte, which resets to the slowest value. The block also shows a prefetch-off flag for each drive, decoded from the control bytes. It flags a revision field of zero as an unsupported configuration.

Top module: `pio_cycle_timer`

## Requirements
- R1: The setup phase length comes from bits 7:6 of the addressed drive's setup byte: code 00 gives 4 clocks, code 10 gives 3, code 01 gives 2 and code 11 gives 5. Full-byte setup writes go to address 1 (drive 0), address 2 (drive 1) and address 3 (secondary channel).
- R2: A timing byte holds the active count in bits 7:4 and the recovery count in bits 3:0, and a nibble of 0 means 16 clocks. Timing bytes go to address 4 (drive 0), address 5 (drive 1) and address 6 (secondary channel).
- R3: An active count of 1 runs as 2 clocks. When the active count is above 3, a recovery count of 1 runs as 2 clocks.
- R4: With `rev_code` greater than 1, recovery lasts one clock more than the decoded count. With `rev_code` equal to 0, `cfg_bad` is high and start pulses are ignored.
- R5: Drives 2 and 3 both use the secondary setup byte and the secondary timing byte.
- R6: `pf_off[0]` is bit 6 and `pf_off[1]` is bit 7 of the control byte (address 0). `pf_off[2]` is bit 2 and `pf_off[3]` is bit 3 of the secondary setup byte. A 1 means prefetch is off.
- R7: Writes to addresses 8, 9 and 10 change only the setup code (data bits 7:6) of drive 0, drive 1 and the secondary channel, and keep the rest of that byte unchanged, including the secondary prefetch bits. Writes to addresses 11 to 15 have no effect.
- R8: A cycle started with `start_cmd` high takes its active and recovery counts from the command-timing byte (address 7, same nibble layout as R2). That byte resets to 0, which gives 16/16. The setup count is still that of the drive.
- R9: Timing is captured when a cycle is accepted. A register write during a cycle affects only later cycles.
- R10: Only the strobe selected by `start_write` is high, and only during the active phase. `busy` is high for setup + active + recovery clocks. `done` is high for exactly the one clock after the last recovery clock. A start pulse while busy is ignored.
- R11: After reset every drive has setup 4, active 16 and recovery 16, and `pf_off` is 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rev_code | input | 2 | Device revision field |
| start | input | 1 | Launch one cycle (sampled while idle) |
| start_drive | input | 2 | Drive index 0..3 |
| start_write | input | 1 | 1 = write strobe, 0 = read strobe |
| start_cmd | input | 1 | Access to the command register block |
| rd_strobe | output | 1 | Read strobe, high during active phase |
| wr_strobe | output | 1 | Write strobe, high during active phase |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse after recovery |
| cfg_bad | output | 1 | Revision field is zero (unsupported) |
| pf_off | output | 4 | Prefetch-off flag for each drive |

## Verification
The hardest situations to reach are those where a register write or a second start pulse arrives while a cycle is already running. The effect shows only as the lengths of the current and the next cycle. The bench's cycle-measuring task can inject a write or a start on the third clock of a cycle. It then checks that the phase lengths still match the values captured at launch, and that the following cycle uses the new byte. Random cycles with random register writes and revisions add interleavings of shared secondary-channel writes and command-block cycles.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_SLOTS = 3;   // drive 0, drive 1, shared secondary
    localparam int SEC_SLOT  = 2;
    localparam int CNT_W     = 5;   // holds up to 17 clocks

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SU0  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TM0  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_FLD0 = ADDR_W'(8);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } phase_counts_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(4);
            2'b10:   return CNT_W'(3);
            2'b01:   return CNT_W'(2);
            default: return CNT_W'(5);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] nib_clocks(input logic [3:0] nib);
        return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
    endfunction

    function automatic phase_counts_t derive_counts(input logic [1:0] code,
                                                    input logic [BYTE_W-1:0] tbyte,
                                                    input logic [1:0] rev);
        phase_counts_t c;
        c.setup  = setup_clocks(code);
        c.active = nib_clocks(tbyte[7:4]);
        c.recov  = nib_clocks(tbyte[3:0]);
        if (c.active == CNT_W'(1))
            c.active = CNT_W'(2);
        if (c.active > CNT_W'(3) && c.recov == CNT_W'(1))
            c.recov = CNT_W'(2);
        if (rev > 2'd1)
            c.recov = c.recov + CNT_W'(1);
        return c;
    endfunction
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_timing_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [BYTE_W-1:0]                   wdata,
    output logic [NUM_SLOTS-1:0][1:0]           su_code,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]    tm_byte,
    output logic [BYTE_W-1:0]                   cmd_byte,
    output logic [3:0]                          pf_off
);
    logic [1:0] ctrl_pf;   // control byte bits 7:6
    logic [1:0] sec_pf;    // secondary setup byte bits 3:2

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic hit_su, hit_fld, hit_tm;
        assign hit_su  = we && (addr == A_SU0  + ADDR_W'(k));
        assign hit_fld = we && (addr == A_FLD0 + ADDR_W'(k));
        assign hit_tm  = we && (addr == A_TM0  + ADDR_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                su_code[k] <= 2'b00;
                tm_byte[k] <= '0;
            end else begin
                if (hit_su || hit_fld)
                    su_code[k] <= wdata[7:6];
                if (hit_tm)
                    tm_byte[k] <= wdata;
            end
        end

        if (k == SEC_SLOT) begin : g_sec_pf
            always_ff @(posedge clk) begin
                if (rst)
                    sec_pf <= 2'b11;
                else if (hit_su)
                    sec_pf <= wdata[3:2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_pf  <= 2'b11;
            cmd_byte <= '0;
        end else if (we) begin
            if (addr == A_CTRL)
                ctrl_pf <= wdata[7:6];
            if (addr == A_CMD)
                cmd_byte <= wdata;
        end
    end

    assign pf_off = {sec_pf, ctrl_pf};
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_timing_pkg::*;
(
    input  logic [1:0]                          drive,
    input  logic                                cmd_sel,
    input  logic [1:0]                          rev,
    input  logic [NUM_SLOTS-1:0][1:0]           su_code,
    input  logic [NUM_SLOTS-1:0][BYTE_W-1:0]    tm_byte,
    input  logic [BYTE_W-1:0]                   cmd_byte,
    output phase_counts_t                       counts
);
    logic [1:0]        slot;
    logic [BYTE_W-1:0] tsel;

    always_comb begin
        slot   = drive[1] ? 2'(SEC_SLOT) : {1'b0, drive[0]};
        tsel   = cmd_sel ? cmd_byte : tm_byte[slot];
        counts = derive_counts(su_code[slot], tsel, rev);
    end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timing_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            go_write,
    input  phase_counts_t   counts_in,
    output logic            rd_strobe,
    output logic            wr_strobe,
    output logic            busy,
    output logic            done
);
    phase_e           phase;
    phase_counts_t    held;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
            cnt   <= '0;
            wr_q  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (go) begin
                    phase <= PH_SETUP;
                    held  <= counts_in;
                    cnt   <= counts_in.setup - CNT_W'(1);
                    wr_q  <= go_write;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_ACTIVE;
                    cnt   <= held.active - CNT_W'(1);
                end else cnt <= cnt - CNT_W'(1);
                PH_ACTIVE: if (cnt == '0) begin
                    phase <= PH_RECOV;
                    cnt   <= held.recov - CNT_W'(1);
                end else cnt <= cnt - CNT_W'(1);
                PH_RECOV: if (cnt == '0) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else cnt <= cnt - CNT_W'(1);
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign rd_strobe = (phase == PH_ACTIVE) && !wr_q;
    assign wr_strobe = (phase == PH_ACTIVE) &&  wr_q;
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        rev_code,
    input  logic              start,
    input  logic [1:0]        start_drive,
    input  logic              start_write,
    input  logic              start_cmd,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              busy,
    output logic              done,
    output logic              cfg_bad,
    output logic [3:0]        pf_off
);
    logic [NUM_SLOTS-1:0][1:0]        su_code;
    logic [NUM_SLOTS-1:0][BYTE_W-1:0] tm_byte;
    logic [BYTE_W-1:0]                cmd_byte;
    phase_counts_t                    counts;

    assign cfg_bad = (rev_code == 2'd0);

    pio_regfile regs_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .su_code(su_code), .tm_byte(tm_byte), .cmd_byte(cmd_byte), .pf_off(pf_off)
    );

    pio_timing_sel sel_i (
        .drive(start_drive), .cmd_sel(start_cmd), .rev(rev_code),
        .su_code(su_code), .tm_byte(tm_byte), .cmd_byte(cmd_byte), .counts(counts)
    );

    pio_phase_seq seq_i (
        .clk(clk), .rst(rst), .go(start && !cfg_bad), .go_write(start_write),
        .counts_in(counts), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .busy(busy), .done(done)
    );
endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cfg_bad,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic busy,
    input logic done
);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe && wr_strobe));

    p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe || wr_strobe) |-> busy);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_setup_first_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_strobe) || $rose(wr_strobe)) |-> $past(busy));

    p_bad_rev_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_bad && start && !busy) |=> !busy);
endmodule

bind pio_cycle_timer pio_cycle_timer_chk chk_i (
    .clk(clk), .rst(rst), .start(start), .cfg_bad(cfg_bad),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .busy(busy), .done(done)
);

// File: tb/pio_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [1:0] rev_code;
    logic       start;
    logic [1:0] start_drive;
    logic       start_write;
    logic       start_cmd;
    logic       rd_strobe, wr_strobe, busy, done, cfg_bad;
    logic [3:0] pf_off;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] m_ctrl;
    logic [7:0] m_su [3];
    logic [7:0] m_tm [3];
    logic [7:0] m_cmd;

    always #4 clk = ~clk;

    pio_cycle_timer dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rev_code(rev_code), .start(start), .start_drive(start_drive),
        .start_write(start_write), .start_cmd(start_cmd), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .busy(busy), .done(done), .cfg_bad(cfg_bad), .pf_off(pf_off)
    );

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void mirror_write(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'd0: m_ctrl = d;
            4'd1, 4'd2, 4'd3: m_su[a - 4'd1] = d;
            4'd4, 4'd5, 4'd6: m_tm[a - 4'd4] = d;
            4'd7: m_cmd = d;
            4'd8, 4'd9, 4'd10: m_su[a - 4'd8] = {d[7:6], m_su[a - 4'd8][5:0]};
            default: ;
        endcase
    endfunction

    function automatic logic [3:0] exp_pf();
        return {m_su[2][3], m_su[2][2], m_ctrl[7], m_ctrl[6]};
    endfunction

    function automatic void exp_counts(input int drv, input bit cmd, input int rev,
                                       output int s, output int a, output int r);
        int slot;
        logic [7:0] su, tb;
        slot = (drv >= 2) ? 2 : drv;
        su = m_su[slot];
        tb = cmd ? m_cmd : m_tm[slot];
        case (su[7:6])
            2'b00: s = 4;
            2'b10: s = 3;
            2'b01: s = 2;
            default: s = 5;
        endcase
        a = (tb[7:4] == 0) ? 16 : int'(tb[7:4]);
        r = (tb[3:0] == 0) ? 16 : int'(tb[3:0]);
        if (a == 1) a = 2;
        if (a > 3 && r == 1) r = 2;
        if (rev > 1) r = r + 1;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        mirror_write(a, d);
    endtask

    // mid: 0 none, 1 register write on third clock, 2 extra start on third clock
    task automatic run_cyc(input int drv, input bit wr, input bit cmd, input string tag,
                           input int mid, input logic [3:0] ma, input logic [7:0] md);
        int es, ea, er, ns, na, nr, k;
        bit seen, dir_ok;
        exp_counts(drv, cmd, int'(rev_code), es, ea, er);
        start = 1'b1; start_drive = 2'(drv); start_write = wr; start_cmd = cmd;
        @(negedge clk);
        start = 1'b0;
        ns = 0; na = 0; nr = 0; k = 0; seen = 0; dir_ok = 1;
        while (busy && k < 200) begin
            if (k == 2 && mid == 1) begin cfg_we = 1'b1; cfg_addr = ma; cfg_wdata = md; end
            if (k == 2 && mid == 2) begin start = 1'b1; start_drive = ~start_drive; end
            if (k == 3) begin
                if (mid == 1) begin cfg_we = 1'b0; mirror_write(ma, md); end
                start = 1'b0;
            end
            if (rd_strobe || wr_strobe) begin
                if (wr_strobe != wr || rd_strobe == wr) dir_ok = 0;
                na++; seen = 1;
            end else if (!seen) ns++;
            else nr++;
            @(negedge clk);
            k++;
        end
        chk(k < 200, {tag, " cycle end"}, k, 0);
        chk(ns == es, {tag, " setup clocks"}, ns, es);
        chk(na == ea, {tag, " active clocks"}, na, ea);
        chk(nr == er, {tag, " recovery clocks"}, nr, er);
        chk(dir_ok, {tag, " R10 strobe direction"}, int'(dir_ok), 1);
        chk(done == 1'b1, {tag, " R10 done after recovery"}, int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " R10 done single, idle"},
            int'({done, busy}), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; rev_code = 2'd1;
        start = 0; start_drive = 0; start_write = 0; start_cmd = 0;
        m_ctrl = 8'hC0; m_su[0] = 0; m_su[1] = 0; m_su[2] = 8'h0C;
        m_tm[0] = 0; m_tm[1] = 0; m_tm[2] = 0; m_cmd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(pf_off == 4'hF, "R11 pf_off after reset", int'(pf_off), 15);
        chk(!busy && !done && !rd_strobe && !wr_strobe && !cfg_bad, "R11 idle outputs",
            int'({busy, done, rd_strobe, wr_strobe, cfg_bad}), 0);
        for (int d = 0; d < 4; d++) run_cyc(d, d[0], 0, "R11 slowest", 0, 0, 0);

        // R1 setup code decode, drive 0
        for (int c = 0; c < 4; c++) begin
            cfg_write(4'd1, 8'(c << 6));
            cfg_write(4'd4, 8'h22);
            run_cyc(0, 0, 0, "R1", 0, 0, 0);
        end

        // R2/R3 nibble decode and stretches, drive 1
        cfg_write(4'd4, 8'h00);
        begin
            logic [7:0] pats [6] = '{8'h11, 8'h41, 8'h31, 8'h05, 8'h20, 8'hFF};
            foreach (pats[i]) begin
                cfg_write(4'd5, pats[i]);
                run_cyc(1, 1, 0, "R2 R3", 0, 0, 0);
            end
        end

        // R4 revision
        rev_code = 2'd2; run_cyc(1, 0, 0, "R4 rev2", 0, 0, 0);
        rev_code = 2'd3; run_cyc(1, 1, 0, "R4 rev3", 0, 0, 0);
        rev_code = 2'd0;
        @(negedge clk);
        chk(cfg_bad == 1'b1, "R4 cfg_bad on rev 0", int'(cfg_bad), 1);
        start = 1'b1; start_drive = 2'd0;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R4 start ignored on rev 0", int'(busy), 0);
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R4 still idle on rev 0", int'({busy, done}), 0);
        rev_code = 2'd1;
        @(negedge clk);
        chk(cfg_bad == 1'b0, "R4 cfg_bad clear", int'(cfg_bad), 0);

        // R5 shared secondary, R6 prefetch bits
        cfg_write(4'd3, 8'h80);
        cfg_write(4'd6, 8'h23);
        chk(pf_off == exp_pf(), "R6 secondary pf bits cleared", int'(pf_off), int'(exp_pf()));
        run_cyc(2, 0, 0, "R5 drive2", 0, 0, 0);
        run_cyc(3, 1, 0, "R5 drive3", 0, 0, 0);
        cfg_write(4'd0, 8'h40);
        chk(pf_off == exp_pf(), "R6 control pf bits", int'(pf_off), int'(exp_pf()));
        cfg_write(4'd0, 8'h80);
        chk(pf_off == exp_pf(), "R6 control pf bits swap", int'(pf_off), int'(exp_pf()));
        cfg_write(4'd3, 8'h88);
        chk(pf_off == exp_pf(), "R6 drive3 pf only", int'(pf_off), int'(exp_pf()));

        // R7 field write keeps low bits; ignored addresses
        cfg_write(4'd10, 8'hC4);
        chk(pf_off == exp_pf(), "R7 field write keeps pf", int'(pf_off), int'(exp_pf()));
        run_cyc(3, 0, 0, "R7 field code", 0, 0, 0);
        cfg_write(4'd12, 8'hFF);
        cfg_write(4'd15, 8'h00);
        chk(pf_off == exp_pf(), "R7 unused address no effect", int'(pf_off), int'(exp_pf()));
        run_cyc(2, 1, 0, "R7 unused address timing", 0, 0, 0);

        // R8 command-block timing
        cfg_write(4'd4, 8'h22);
        run_cyc(0, 0, 1, "R8 cmd reset 16/16", 0, 0, 0);
        cfg_write(4'd7, 8'h35);
        run_cyc(0, 1, 1, "R8 cmd programmed", 0, 0, 0);
        run_cyc(0, 1, 0, "R8 non-cmd unaffected", 0, 0, 0);

        // R9 write during a cycle
        run_cyc(0, 0, 0, "R9 captured", 1, 4'd4, 8'h93);
        run_cyc(0, 0, 0, "R9 next cycle", 0, 0, 0);

        // R10 start while busy ignored
        run_cyc(1, 1, 0, "R10 busy start", 2, 0, 0);

        // random mix
        for (int it = 0; it < 120; it++) begin
            rev_code = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 1) == 1)
                cfg_write(4'($urandom_range(0, 15)), 8'($urandom));
            chk(pf_off == exp_pf(), "R6 random pf", int'(pf_off), int'(exp_pf()));
            run_cyc(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) == 0), "R1 R2 R3 R4 random", 0, 0, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule